// File: doc/BRIEF.md
# Secure Reset and Fuse Distribution Sequencer

This block is the first piece of a processor subsystem to leave power-on reset. It asks the configuration subsystem for the security fuse word and captures the returned word in a shadow register. It checks every security option for a legal encoding. If all checks pass, it hands each decoded field to its consumer: the clock manager, the reset manager, and a boot policy register that boot firmware can read. Only after these steps does it release the peripheral reset and then the CPU0 reset. It also drives the debug-access policy outputs from two of the fuse bits.

A failed check, or a fuse handshake that does not complete within a limit set at a port, puts the sequencer into a terminal error state. In that state CPU0 and the peripherals stay in reset and a sticky error flag is raised. Only a new power-on reset leaves the error state. In the shadow word a 1 means a blown fuse and a 0 means an unblown fuse.

Fuse word layout: clock control in bits [3:0], memory control in bits [7:4], authentication enable in bit 8, encryption enable in bit 9, key source in bits [11:10], key length in bits [13:12], debug disable-access in bit 14, debug lock in bit 15. Bits 16 and above are reserved.

Top module: `secboot_rst_seq`

## Requirements
- R1: While reset is asserted, `cfg_req`, `periph_rst_n`, `cpu0_rst_n` and `err_flag` are all 0. One cycle after reset is released, `cfg_req` goes high. While `cfg_req` is high, `periph_rst_n` and `cpu0_rst_n` stay 0.
- R2: The shadow register captures `cfg_data` on the clock edge where `cfg_valid` and `cfg_req` are both high. Reading `bus_addr`=0 returns the captured word bit for bit.
- R3: The word is illegal, and the sequencer enters the error state, if any of these holds: key source is 2'b11, key length is 2'b11, or the debug pair (disable-access, lock) is 1/0. Any reserved bit set to 1 also makes the word illegal.
- R4: Request cycles are counted from 0. A `cfg_valid` in request cycles 0 to `timeout_lim`-1 is accepted. When request cycle `timeout_lim` is reached, the sequencer enters the error state, even if `cfg_valid` is high in that cycle.
- R5: For a legal word, `clkmgr_load` pulses for one cycle, two cycles after capture, with the clock field on `clkmgr_fuse`. In the next cycle `rstmgr_load` pulses with the memory field on `rstmgr_fuse`. Both fields hold their values afterwards.
- R6: Reading `bus_addr`=1 returns the boot policy word in bits [5:0]: {key length, key source, encryption enable, authentication enable}, with authentication enable in bit 0. This word reads as 0 until it is published, one cycle after `rstmgr_load`.
- R7: `periph_rst_n` rises two cycles after the `rstmgr_load` pulse. `cpu0_rst_n` rises exactly one cycle later. Once released, neither reset is asserted again before the next power-on reset.
- R8: In the error state, `err_flag` is 1 and stays 1, and both resets stay asserted. Reading `bus_addr`=2 returns 2'b01. A later `cfg_valid` changes nothing.
- R9: The debug outputs depend on the debug pair (disable-access, lock). The pair 0/0 gives in-chain=1, software-enable=1, locked=0. The pair 0/1 gives 1/0/1. The pair 1/1 gives 0/0/1. Before a legal word has been decoded, and in the error state, the outputs are 0/0/1.
- R10: After the request phase has ended, `cfg_valid` has no effect on the shadow register.
- R11: After `cpu0_rst_n` is released, reading `bus_addr`=2 returns 2'b10 (done=1, error=0). Reading `bus_addr`=3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| timeout_lim | input | TMO_W | Number of request cycles allowed for the fuse handshake |
| cfg_req | output | 1 | Fuse data request to the configuration subsystem |
| cfg_valid | input | 1 | Fuse data valid |
| cfg_data | input | FUSE_W | Fuse word |
| clkmgr_fuse | output | 4 | Clock control field for the clock manager |
| clkmgr_load | output | 1 | One-cycle load strobe for the clock manager |
| rstmgr_fuse | output | 4 | Memory control field for the reset manager |
| rstmgr_load | output | 1 | One-cycle load strobe for the reset manager |
| periph_rst_n | output | 1 | Peripheral reset, active low, released in the secure state |
| cpu0_rst_n | output | 1 | CPU0 reset, active low, released last |
| err_flag | output | 1 | Sticky error flag for a failed check or timeout |
| jtag_in_chain | output | 1 | Subsystem is present in the JTAG chain |
| jtag_sw_en | output | 1 | Debug is under software control |
| jtag_locked | output | 1 | Debug access is locked |
| bus_addr | input | 2 | Read address: 0 shadow, 1 boot policy, 2 status, 3 zero |
| bus_rdata | output | FUSE_W | Read data for `bus_addr`, combinational |

## Verification
The bench runs three legal fuse words. Each uses a different clock field, memory field, key source, key length and debug pair, so a swapped or shifted field shows up in the distributed values, the readback words and the debug outputs. Four illegal words each break exactly one legality rule, which shows that every rule is checked on its own. Two handshakes arrive at request cycles `timeout_lim`-1 and `timeout_lim`; they separate acceptance from timeout at the exact boundary. A third handshake never arrives. A scoreboard checks the order of the distribution and release events, and the cycle gap between them. Late `cfg_valid` pulses, sent after completion and after an error, check that the shadow register and the error state cannot be changed.

// File: rtl/srs_pkg.sv
package srs_pkg;

    // Field positions within the fuse word
    localparam int CLK_LSB      = 0;
    localparam int CLK_W        = 4;
    localparam int MEM_LSB      = 4;
    localparam int MEM_W        = 4;
    localparam int AUTH_BIT     = 8;
    localparam int ENC_BIT      = 9;
    localparam int KSRC_LSB     = 10;
    localparam int KLEN_LSB     = 12;
    localparam int DBG_DIS_BIT  = 14;
    localparam int DBG_LOCK_BIT = 15;
    localparam int RSV_LSB      = 16;
    localparam int BOOT_W       = 6;
    localparam int N_RULES      = 4;

    typedef enum logic [3:0] {
        S_IDLE,
        S_REQ,
        S_CHECK,
        S_CLK,
        S_MEM,
        S_PUB,
        S_PERIPH,
        S_DONE,
        S_ERR
    } seq_state_e;

    typedef struct packed {
        logic [CLK_W-1:0] clk_ctl;
        logic [MEM_W-1:0] mem_ctl;
        logic             auth_en;
        logic             enc_en;
        logic [1:0]       key_src;
        logic [1:0]       key_len;
        logic             dbg_dis;
        logic             dbg_lock;
    } fuse_fields_t;

endpackage

// File: rtl/srs_fuse_decode.sv
module srs_fuse_decode
    import srs_pkg::*;
#(
    parameter int FUSE_W = 32
) (
    input  logic [FUSE_W-1:0] shadow,
    output fuse_fields_t      fields,
    output logic              legal
);

    logic [N_RULES-1:0] rule_fail;

    always_comb begin
        fields.clk_ctl  = shadow[CLK_LSB +: CLK_W];
        fields.mem_ctl  = shadow[MEM_LSB +: MEM_W];
        fields.auth_en  = shadow[AUTH_BIT];
        fields.enc_en   = shadow[ENC_BIT];
        fields.key_src  = shadow[KSRC_LSB +: 2];
        fields.key_len  = shadow[KLEN_LSB +: 2];
        fields.dbg_dis  = shadow[DBG_DIS_BIT];
        fields.dbg_lock = shadow[DBG_LOCK_BIT];
    end

    // One legality rule per security option
    always_comb begin
        rule_fail[0] = (shadow[KSRC_LSB +: 2] == 2'b11);
        rule_fail[1] = (shadow[KLEN_LSB +: 2] == 2'b11);
        rule_fail[2] = shadow[DBG_DIS_BIT] && !shadow[DBG_LOCK_BIT];
        rule_fail[3] = |shadow[FUSE_W-1:RSV_LSB];
    end

    assign legal = ~|rule_fail;

endmodule

// File: rtl/srs_req_timer.sv
module srs_req_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);

    localparam logic [TMO_W-1:0] CNT_MAX = '1;

    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = run && (cnt_q >= limit);

endmodule

// File: rtl/srs_dbg_policy.sv
module srs_dbg_policy (
    input  logic decoded,
    input  logic dbg_dis,
    input  logic dbg_lock,
    output logic in_chain,
    output logic sw_en,
    output logic locked
);

    always_comb begin
        in_chain = 1'b0;
        sw_en    = 1'b0;
        locked   = 1'b1;
        if (decoded) begin
            unique case ({dbg_dis, dbg_lock})
                2'b00: begin
                    in_chain = 1'b1;
                    sw_en    = 1'b1;
                    locked   = 1'b0;
                end
                2'b01: begin
                    in_chain = 1'b1;
                    sw_en    = 1'b0;
                    locked   = 1'b1;
                end
                default: begin
                    in_chain = 1'b0;
                    sw_en    = 1'b0;
                    locked   = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/secboot_rst_seq.sv
module secboot_rst_seq
    import srs_pkg::*;
#(
    parameter int FUSE_W = 32,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMO_W-1:0]  timeout_lim,
    output logic              cfg_req,
    input  logic              cfg_valid,
    input  logic [FUSE_W-1:0] cfg_data,
    output logic [CLK_W-1:0]  clkmgr_fuse,
    output logic              clkmgr_load,
    output logic [MEM_W-1:0]  rstmgr_fuse,
    output logic              rstmgr_load,
    output logic              periph_rst_n,
    output logic              cpu0_rst_n,
    output logic              err_flag,
    output logic              jtag_in_chain,
    output logic              jtag_sw_en,
    output logic              jtag_locked,
    input  logic [1:0]        bus_addr,
    output logic [FUSE_W-1:0] bus_rdata
);

    typedef struct packed {
        seq_state_e        st;
        logic [FUSE_W-1:0] shadow;
        logic [CLK_W-1:0]  clkf;
        logic [MEM_W-1:0]  memf;
        logic [BOOT_W-1:0] boot;
        logic              err;
        logic              decoded;
    } seq_regs_t;

    seq_regs_t    r_d, r_q;
    fuse_fields_t fld;
    logic         legal;
    logic         tmo_expired;
    logic         in_req;

    assign in_req = (r_q.st == S_REQ);

    srs_fuse_decode #(.FUSE_W(FUSE_W)) u_decode (
        .shadow (r_q.shadow),
        .fields (fld),
        .legal  (legal)
    );

    srs_req_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (in_req),
        .limit   (timeout_lim),
        .expired (tmo_expired)
    );

    srs_dbg_policy u_dbg (
        .decoded  (r_q.decoded && !r_q.err),
        .dbg_dis  (fld.dbg_dis),
        .dbg_lock (fld.dbg_lock),
        .in_chain (jtag_in_chain),
        .sw_en    (jtag_sw_en),
        .locked   (jtag_locked)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            S_IDLE: r_d.st = S_REQ;
            S_REQ: begin
                if (tmo_expired) begin
                    r_d.err = 1'b1;
                    r_d.st  = S_ERR;
                end else if (cfg_valid) begin
                    r_d.shadow = cfg_data;
                    r_d.st     = S_CHECK;
                end
            end
            S_CHECK: begin
                if (legal) begin
                    r_d.decoded = 1'b1;
                    r_d.clkf    = fld.clk_ctl;
                    r_d.st      = S_CLK;
                end else begin
                    r_d.err = 1'b1;
                    r_d.st  = S_ERR;
                end
            end
            S_CLK: begin
                r_d.memf = fld.mem_ctl;
                r_d.st   = S_MEM;
            end
            S_MEM: begin
                r_d.boot = {fld.key_len, fld.key_src, fld.enc_en, fld.auth_en};
                r_d.st   = S_PUB;
            end
            S_PUB:    r_d.st = S_PERIPH;
            S_PERIPH: r_d.st = S_DONE;
            S_DONE:   r_d.st = S_DONE;
            S_ERR:    r_d.st = S_ERR;
            default: begin
                r_d.err = 1'b1;
                r_d.st  = S_ERR;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, shadow: '0, clkf: '0, memf: '0,
                     boot: '0, err: 1'b0, decoded: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_req      = in_req;
    assign clkmgr_fuse  = r_q.clkf;
    assign clkmgr_load  = (r_q.st == S_CLK);
    assign rstmgr_fuse  = r_q.memf;
    assign rstmgr_load  = (r_q.st == S_MEM);
    assign periph_rst_n = (r_q.st == S_PERIPH) || (r_q.st == S_DONE);
    assign cpu0_rst_n   = (r_q.st == S_DONE);
    assign err_flag     = r_q.err;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            2'd0: bus_rdata = r_q.shadow;
            2'd1: bus_rdata[BOOT_W-1:0] = r_q.boot;
            2'd2: bus_rdata[1:0] = {r_q.st == S_DONE, r_q.err};
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/srs_seq_checker.sv
module srs_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_req,
    input logic clkmgr_load,
    input logic rstmgr_load,
    input logic periph_rst_n,
    input logic cpu0_rst_n,
    input logic err_flag,
    input logic jtag_in_chain,
    input logic jtag_sw_en,
    input logic jtag_locked
);

    assert_hold_in_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (!periph_rst_n && !cpu0_rst_n));

    assert_mem_after_clk_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clkmgr_load |=> rstmgr_load);

    assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clkmgr_load, rstmgr_load, cfg_req}));

    assert_cpu_after_periph_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu0_rst_n) |-> $past(periph_rst_n));

    assert_periph_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
        periph_rst_n |=> periph_rst_n);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    assert_err_holds_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> (!cpu0_rst_n && !periph_rst_n && !clkmgr_load && !rstmgr_load));

    assert_dbg_consistent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        jtag_sw_en |-> (jtag_in_chain && !jtag_locked));

    assert_dbg_safe_on_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> (!jtag_in_chain && jtag_locked));

endmodule

bind secboot_rst_seq srs_seq_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_req       (cfg_req),
    .clkmgr_load   (clkmgr_load),
    .rstmgr_load   (rstmgr_load),
    .periph_rst_n  (periph_rst_n),
    .cpu0_rst_n    (cpu0_rst_n),
    .err_flag      (err_flag),
    .jtag_in_chain (jtag_in_chain),
    .jtag_sw_en    (jtag_sw_en),
    .jtag_locked   (jtag_locked)
);

// File: tb/secboot_rst_seq_tb_top.sv
module secboot_rst_seq_tb_top;

    localparam int FW = 32;
    localparam int TW = 16;

    localparam int EV_CLK = 1;
    localparam int EV_MEM = 2;
    localparam int EV_PER = 3;
    localparam int EV_CPU = 4;
    localparam int EV_ERR = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] timeout_lim = 16'd8;
    logic          cfg_req;
    logic          cfg_valid = 1'b0;
    logic [FW-1:0] cfg_data = '0;
    logic [3:0]    clkmgr_fuse;
    logic          clkmgr_load;
    logic [3:0]    rstmgr_fuse;
    logic          rstmgr_load;
    logic          periph_rst_n;
    logic          cpu0_rst_n;
    logic          err_flag;
    logic          jtag_in_chain;
    logic          jtag_sw_en;
    logic          jtag_locked;
    logic [1:0]    bus_addr = 2'd0;
    logic [FW-1:0] bus_rdata;

    always #5 clk = ~clk;

    secboot_rst_seq #(.FUSE_W(FW), .TMO_W(TW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .timeout_lim   (timeout_lim),
        .cfg_req       (cfg_req),
        .cfg_valid     (cfg_valid),
        .cfg_data      (cfg_data),
        .clkmgr_fuse   (clkmgr_fuse),
        .clkmgr_load   (clkmgr_load),
        .rstmgr_fuse   (rstmgr_fuse),
        .rstmgr_load   (rstmgr_load),
        .periph_rst_n  (periph_rst_n),
        .cpu0_rst_n    (cpu0_rst_n),
        .err_flag      (err_flag),
        .jtag_in_chain (jtag_in_chain),
        .jtag_sw_en    (jtag_sw_en),
        .jtag_locked   (jtag_locked),
        .bus_addr      (bus_addr),
        .bus_rdata     (bus_rdata)
    );

    typedef struct {
        int code;
        int data;
        int gap;
    } ev_t;

    ev_t exp_q[$];
    int  n_tests = 0;
    int  n_fail  = 0;
    int  cyc     = 0;
    int  last_cyc = 0;
    bit  done_flag = 1'b0;
    logic prev_per = 1'b0, prev_cpu = 1'b0, prev_err = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    task automatic push(input int code, input int data, input int gap);
        ev_t e;
        e.code = code;
        e.data = data;
        e.gap  = gap;
        exp_q.push_back(e);
    endtask

    task automatic got(input int code, input int data);
        ev_t e;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R7", "unexpected event", code, 0);
        end else begin
            e = exp_q.pop_front();
            chk(e.code == code, "R7", "event order", code, e.code);
            chk(e.data == data, "R5", "distributed field", data, e.data);
            if (e.gap > 0)
                chk(cyc - last_cyc == e.gap, "R7", "event spacing", cyc - last_cyc, e.gap);
        end
        last_cyc = cyc;
    endtask

    // Monitor: scoreboard side
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (clkmgr_load) got(EV_CLK, int'(clkmgr_fuse));
            if (rstmgr_load) got(EV_MEM, int'(rstmgr_fuse));
            if (periph_rst_n && !prev_per) got(EV_PER, 0);
            if (cpu0_rst_n && !prev_cpu) got(EV_CPU, 0);
            if (err_flag && !prev_err) got(EV_ERR, 0);
            prev_per = periph_rst_n;
            prev_cpu = cpu0_rst_n;
            prev_err = err_flag;
        end else begin
            prev_per = 1'b0;
            prev_cpu = 1'b0;
            prev_err = 1'b0;
        end
    end

    task automatic rd(input logic [1:0] a, output logic [FW-1:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic do_reset(input int lim);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_valid = 1'b0;
        timeout_lim = TW'(lim);
        repeat (2) @(negedge clk);
        chk(!cfg_req && !periph_rst_n && !cpu0_rst_n && !err_flag, "R1", "reset state",
            {cfg_req, periph_rst_n, cpu0_rst_n, err_flag}, 0);
        chk(!jtag_in_chain && !jtag_sw_en && jtag_locked, "R9", "dbg in reset",
            {jtag_in_chain, jtag_sw_en, jtag_locked}, 3'b001);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_req == 1'b1, "R1", "request raised", cfg_req, 1);
        chk(!periph_rst_n && !cpu0_rst_n, "R1", "held during request",
            {periph_rst_n, cpu0_rst_n}, 0);
    endtask

    // delay < 0: never send valid
    task automatic send(input logic [FW-1:0] w, input int delay);
        if (delay >= 0) begin
            repeat (delay) @(negedge clk);
            cfg_data  = w;
            cfg_valid = 1'b1;
            @(negedge clk);
            cfg_valid = 1'b0;
        end
    endtask

    task automatic run_ok(input logic [FW-1:0] w, input int lim, input int delay,
                          input logic [5:0] boot_exp, input logic [2:0] dbg_exp);
        logic [FW-1:0] v;
        do_reset(lim);
        push(EV_CLK, int'(w[3:0]), 0);
        push(EV_MEM, int'(w[7:4]), 1);
        push(EV_PER, 0, 2);
        push(EV_CPU, 0, 1);
        rd(2'd1, v);
        chk(v == 0, "R6", "boot word before publish", v, 0);
        send(w, delay);
        repeat (8) @(negedge clk);
        chk(exp_q.size() == 0, "R7", "events outstanding", exp_q.size(), 0);
        chk(cpu0_rst_n && periph_rst_n && !err_flag, "R7", "released",
            {cpu0_rst_n, periph_rst_n, err_flag}, 3'b110);
        rd(2'd0, v);
        chk(v == w, "R2", "shadow readback", v, w);
        rd(2'd1, v);
        chk(v == FW'(boot_exp), "R6", "boot policy", v, boot_exp);
        rd(2'd2, v);
        chk(v == 2, "R11", "status done", v, 2);
        rd(2'd3, v);
        chk(v == 0, "R11", "addr 3 zero", v, 0);
        chk({jtag_in_chain, jtag_sw_en, jtag_locked} == dbg_exp, "R9", "debug policy",
            {jtag_in_chain, jtag_sw_en, jtag_locked}, dbg_exp);
        chk(clkmgr_fuse == w[3:0] && rstmgr_fuse == w[7:4], "R5", "fields held",
            {clkmgr_fuse, rstmgr_fuse}, {w[3:0], w[7:4]});
        // late valid must not touch the shadow register
        send(~w, 0);
        repeat (2) @(negedge clk);
        rd(2'd0, v);
        chk(v == w, "R10", "shadow after late valid", v, w);
    endtask

    task automatic run_err(input logic [FW-1:0] w, input int lim, input int delay,
                           input string req);
        logic [FW-1:0] v;
        do_reset(lim);
        push(EV_ERR, 0, 0);
        send(w, delay);
        repeat (lim + 8) @(negedge clk);
        chk(exp_q.size() == 0, req, "error event outstanding", exp_q.size(), 0);
        chk(err_flag && !cpu0_rst_n && !periph_rst_n, req, "error state",
            {err_flag, cpu0_rst_n, periph_rst_n}, 3'b100);
        rd(2'd2, v);
        chk(v == 1, "R8", "status error", v, 1);
        chk({jtag_in_chain, jtag_sw_en, jtag_locked} == 3'b001, "R9", "debug on error",
            {jtag_in_chain, jtag_sw_en, jtag_locked}, 3'b001);
        send(32'h0000_015A, 0);
        repeat (4) @(negedge clk);
        chk(err_flag && !cpu0_rst_n, "R8", "error sticky after valid",
            {err_flag, cpu0_rst_n}, 2'b10);
    endtask

    initial begin
        // Legal words: different fields, key settings and debug pairs
        run_ok(32'h0000_015A, 8, 0, 6'h01, 3'b110);   // dbg 0/0
        run_ok(32'h0000_97C3, 8, 2, 6'h17, 3'b101);   // dbg 0/1
        run_ok(32'h0000_C8F0, 8, 1, 6'h08, 3'b001);   // dbg 1/1
        // R4 boundary: last accepted request cycle
        run_ok(32'h0000_015A, 4, 3, 6'h01, 3'b110);
        // R3 illegal encodings, one rule each
        run_err(32'h0000_0C00, 8, 0, "R3");            // key source 11
        run_err(32'h0000_3000, 8, 0, "R3");            // key length 11
        run_err(32'h0000_4000, 8, 0, "R3");            // debug pair 1/0
        run_err(32'h0010_0000, 8, 0, "R3");            // reserved bit
        // R4 timeouts
        run_err(32'h0000_015A, 4, 4, "R4");            // valid at the limit cycle
        run_err(32'h0000_015A, 5, -1, "R4");           // never valid
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule